// File: doc/BRIEF.md
# SDRAM Burst Column Address Sequencer

This block produces the column addresses of one SDRAM burst, one per clock. A controller writes a mode word into the block's mode register. It then pulses a start strobe together with a read/write flag and the first column of the access. From the next cycle on, the block drives a column address with a valid flag for each beat of the burst, and it raises a done pulse on the final beat.

The number of beats and the order of the beats come from the stored mode word. Bursts can be 1, 2, 4 or 8 beats long. Beats can wrap upward inside an aligned block or follow an XOR pattern. A write-through mode turns every write into a single beat while reads keep the programmed length. A new start strobe during a burst cuts that burst short, and the new burst begins at once.

Top module: `sdram_bseq_colseq`

## Requirements
- R1: While `rst_n` is low, `col_valid` and `burst_done` are low. Reset loads a default mode: 1 beat, sequential order, normal writes.
- R2: A cycle with `mode_wr` high stores `mode_word`. Bits [2:0] give the length: 000 is 1 beat, 001 is 2, 010 is 4, 011 is 8, and any other code is 1. Bit 3 picks the order (0 sequential, 1 interleaved). Bit 9 set to 1 selects single-write mode. A start in the same cycle as `mode_wr` still uses the previously stored mode.
- R3: After a start strobe sampled at a clock edge, `col_valid` is high from the next cycle for exactly the burst length in consecutive cycles. The first beat's address equals `start_col`.
- R4: In sequential order, the low field of beat k is (start offset + k) modulo the length, so the beats wrap inside the aligned block. An 8-beat burst from offset 5 gives 5,6,7,0,1,2,3,4.
- R5: In interleaved order, the low field of beat k is the start offset XOR k. An 8-beat burst from offset 5 gives 5,4,7,6,1,0,3,2.
- R6: The burst field is bit 0 for 2 beats, bits 1:0 for 4 beats and bits 2:0 for 8 beats. Every column bit above that field keeps its `start_col` value for the whole burst.
- R7: `burst_done` is high only together with `col_valid`, on the last beat of each burst.
- R8: In single-write mode a write burst has exactly one beat, and a read burst has the programmed length.
- R9: In normal mode, writes and reads both run for the programmed length.
- R10: A start strobe during an active burst ends that burst. The new burst's first beat appears in the next cycle.
- R11: `is_write` and `start_col` are used only in the start cycle. Changes to them during a burst have no effect on that burst.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| mode_wr | input | 1 | Store `mode_word` into the mode register |
| mode_word | input | 13 | Mode word (length, order, single-write bit) |
| start | input | 1 | Begin a burst |
| is_write | input | 1 | 1 for a write burst, 0 for a read burst |
| start_col | input | 12 | First column of the burst |
| col_addr | output | 12 | Column address of the current beat |
| col_valid | output | 1 | `col_addr` carries a beat |
| burst_done | output | 1 | Current beat is the last one |

## Verification
The assertions assume that `start`, `is_write` and `start_col` carry known values on every edge after reset. They also assume that a start cycle means a new burst even if a burst is already running, so the first-beat property compares against the start column of the most recent strobe. The stimulus drives all inputs at the falling edge only and always to defined values. It mixes directed bursts with random bursts that sometimes land on active beats. The behavioural model follows the aborted bursts as well.

// File: rtl/sdram_bseq_pkg.sv
// Package: shared types and helpers for the burst column sequencer.
// Assumes bursts never exceed 2**MAX_LG beats.
package sdram_bseq_pkg;

    localparam int MAX_LG = 3;
    localparam int LG_W   = $clog2(MAX_LG + 1);

    typedef logic [MAX_LG-1:0] beat_t;
    typedef logic [LG_W-1:0]   lg_t;

    typedef enum logic {
        ORD_SEQ   = 1'b0,
        ORD_INTLV = 1'b1
    } order_e;

    typedef struct packed {
        lg_t    len_lg;
        order_e order;
        logic   wr_single;
    } mode_t;

    // Map the 3-bit length code to log2 of the beat count; unknown codes mean 1 beat.
    function automatic lg_t decode_len(input logic [2:0] code);
        case (code)
            3'b001:  decode_len = lg_t'(1);
            3'b010:  decode_len = lg_t'(2);
            3'b011:  decode_len = lg_t'(3);
            default: decode_len = lg_t'(0);
        endcase
    endfunction

    // Mask with the low len_lg bits set: the field that moves inside one burst.
    function automatic beat_t low_mask(input lg_t len_lg);
        beat_t m;
        for (int i = 0; i < MAX_LG; i++) begin
            m[i] = (i < int'(len_lg));
        end
        return m;
    endfunction

endpackage

// File: rtl/sdram_bseq_mode.sv
// Module: mode register. It stores the length, order and single-write fields
// of the mode word. Assumes mode_word is valid whenever mode_wr is high.
module sdram_bseq_mode
    import sdram_bseq_pkg::*;
#(
    parameter int MODE_W  = 13,
    parameter int LEN_LSB = 0,
    parameter int ORD_BIT = 3,
    parameter int WS_BIT  = 9
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mode_wr,
    input  logic [MODE_W-1:0] mode_word,
    output mode_t             mode_q
);

    // Load default mode on reset, capture fields on a mode write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q.len_lg    <= '0;
            mode_q.order     <= ORD_SEQ;
            mode_q.wr_single <= 1'b0;
        end else if (mode_wr) begin
            mode_q.len_lg    <= decode_len(mode_word[LEN_LSB +: 3]);
            mode_q.order     <= order_e'(mode_word[ORD_BIT]);
            mode_q.wr_single <= mode_word[WS_BIT];
        end
    end

endmodule

// File: rtl/sdram_bseq_ctrl.sv
// Module: burst controller. It tracks the active flag and the beat index,
// and it latches the effective length and order at start. A start always
// restarts the burst, even in the middle of one.
module sdram_bseq_ctrl
    import sdram_bseq_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    input  logic   start,
    input  logic   is_write,
    input  mode_t  mode_q,
    output logic   active,
    output beat_t  beat,
    output lg_t    len_lg_q,
    output order_e order_q,
    output logic   last
);

    beat_t last_idx;

    // Index of the final beat for the latched length.
    always_comb last_idx = low_mask(len_lg_q);

    // Last beat flag, qualified by active.
    always_comb last = active && (beat == last_idx);

    // Burst state: restart on start, advance or finish otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active   <= 1'b0;
            beat     <= '0;
            len_lg_q <= '0;
            order_q  <= ORD_SEQ;
        end else if (start) begin
            active   <= 1'b1;
            beat     <= '0;
            len_lg_q <= (is_write && mode_q.wr_single) ? lg_t'(0) : mode_q.len_lg;
            order_q  <= mode_q.order;
        end else if (active) begin
            if (last) begin
                active <= 1'b0;
            end else begin
                beat <= beat + beat_t'(1);
            end
        end
    end

endmodule

// File: rtl/sdram_bseq_addr.sv
// Module: column address generator. It holds the start column and forms
// each beat's address from the beat index, the length and the order.
// Bits above the burst field always come from the stored column.
module sdram_bseq_addr
    import sdram_bseq_pkg::*;
#(
    parameter int COL_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [COL_W-1:0] start_col,
    input  lg_t              len_lg,
    input  order_e           order,
    input  beat_t            beat,
    output logic [COL_W-1:0] col_addr
);

    localparam int HI_W = COL_W - MAX_LG;

    logic [COL_W-1:0] base_q;
    beat_t            off;
    beat_t            mask;
    beat_t            seq_low;
    beat_t            int_low;
    beat_t            pick;
    beat_t            low;

    // Hold the start column for the duration of the burst.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            base_q <= '0;
        end else if (start) begin
            base_q <= start_col;
        end
    end

    // Candidate low fields for both orders.
    always_comb begin
        off     = base_q[MAX_LG-1:0];
        mask    = low_mask(len_lg);
        seq_low = off + beat;
        int_low = off ^ beat;
    end

    // Choose the order, keep untouched low bits, prepend the held upper part.
    always_comb begin
        pick     = (order == ORD_INTLV) ? int_low : seq_low;
        low      = (off & ~mask) | (pick & mask);
        col_addr = {base_q[COL_W-1 -: HI_W], low};
    end

endmodule

// File: rtl/sdram_bseq_colseq.sv
// Module: top of the burst column sequencer. It ties the mode register, the
// burst controller and the address generator together. Outputs are driven
// from registered state only, so the first beat follows start by one cycle.
module sdram_bseq_colseq
    import sdram_bseq_pkg::*;
#(
    parameter int COL_W   = 12,
    parameter int MODE_W  = 13,
    parameter int ORD_BIT = 3,
    parameter int WS_BIT  = 9
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mode_wr,
    input  logic [MODE_W-1:0] mode_word,
    input  logic              start,
    input  logic              is_write,
    input  logic [COL_W-1:0]  start_col,
    output logic [COL_W-1:0]  col_addr,
    output logic              col_valid,
    output logic              burst_done
);

    mode_t  mode_q;
    logic   active;
    beat_t  beat;
    lg_t    len_lg_q;
    order_e order_q;
    logic   last;
    logic   wr_single_mode;

    sdram_bseq_mode #(
        .MODE_W  (MODE_W),
        .LEN_LSB (0),
        .ORD_BIT (ORD_BIT),
        .WS_BIT  (WS_BIT)
    ) u_mode (
        .clk       (clk),
        .rst_n     (rst_n),
        .mode_wr   (mode_wr),
        .mode_word (mode_word),
        .mode_q    (mode_q)
    );

    sdram_bseq_ctrl u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (start),
        .is_write (is_write),
        .mode_q   (mode_q),
        .active   (active),
        .beat     (beat),
        .len_lg_q (len_lg_q),
        .order_q  (order_q),
        .last     (last)
    );

    sdram_bseq_addr #(
        .COL_W (COL_W)
    ) u_addr (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start),
        .start_col (start_col),
        .len_lg    (len_lg_q),
        .order     (order_q),
        .beat      (beat),
        .col_addr  (col_addr)
    );

    // Drive the outputs from the controller state.
    always_comb begin
        col_valid      = active;
        burst_done     = last;
        wr_single_mode = mode_q.wr_single;
    end

endmodule

// File: rtl/sdram_bseq_colseq_chk.sv
// Module: checker for the burst column sequencer, bound to the top module.
// Assumes the inputs carry known values after reset.
module sdram_bseq_colseq_chk #(
    parameter int COL_W  = 12,
    parameter int MAX_LG = 3
) (
    input logic             clk,
    input logic             rst_n,
    input logic             start,
    input logic             is_write,
    input logic [COL_W-1:0] start_col,
    input logic [COL_W-1:0] col_addr,
    input logic             col_valid,
    input logic             burst_done,
    input logic             wr_single_mode
);

    // R3 / R10: a start produces a beat at the start column in the next cycle.
    assert_first_beat_R3: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> (col_valid && col_addr == $past(start_col)));

    // R7: done only on a valid beat.
    assert_done_valid_R7: assert property (@(posedge clk) disable iff (!rst_n)
        burst_done |-> col_valid);

    // R3: after the last beat, with no new start, the burst ends.
    assert_stop_after_done_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (burst_done && !start) |=> !col_valid);

    // R6: upper column bits stay put within one burst.
    assert_upper_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (col_valid && !start) |=> (!col_valid || $stable(col_addr[COL_W-1:MAX_LG])));

    // R8: a write in single-write mode is a one-beat burst.
    assert_write_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (start && is_write && wr_single_mode) |=> burst_done);

endmodule

bind sdram_bseq_colseq sdram_bseq_colseq_chk #(
    .COL_W  (COL_W),
    .MAX_LG (sdram_bseq_pkg::MAX_LG)
) u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .start          (start),
    .is_write       (is_write),
    .start_col      (start_col),
    .col_addr       (col_addr),
    .col_valid      (col_valid),
    .burst_done     (burst_done),
    .wr_single_mode (wr_single_mode)
);

// File: tb/sdram_bseq_colseq_tb.sv
// Bench: behavioural reference model compared on every clock, plus directed
// sequence checks for the ordering examples and mode corner cases.
module sdram_bseq_colseq_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        mode_wr = 1'b0;
    logic [12:0] mode_word = '0;
    logic        start = 1'b0;
    logic        is_write = 1'b0;
    logic [11:0] start_col = '0;
    logic [11:0] col_addr;
    logic        col_valid;
    logic        burst_done;

    int checks = 0;
    int failures = 0;
    bit finished = 0;

    // Model state
    int m_code = 0, m_ord = 0, m_single = 0;
    int act = 0, bt = 0, blen = 1, bbase = 0, bord = 0;

    // Capture queue for directed checks
    bit cap_en = 0;
    int capq[$];

    always #2.5 clk = ~clk;

    sdram_bseq_colseq u_dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .mode_wr    (mode_wr),
        .mode_word  (mode_word),
        .start      (start),
        .is_write   (is_write),
        .start_col  (start_col),
        .col_addr   (col_addr),
        .col_valid  (col_valid),
        .burst_done (burst_done)
    );

    function automatic int len_of(int code);
        case (code)
            1: return 2;
            2: return 4;
            3: return 8;
            default: return 1;
        endcase
    endfunction

    function automatic int exp_addr(int base, int len, int ord, int k);
        int off = base % len;
        int low = ord ? (off ^ k) : ((off + k) % len);
        return base - off + low;
    endfunction

    task automatic check(bit ok, string req, int actual, int expected);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, actual, expected, $time);
        end
    endtask

    // Reference model: update on every rising edge.
    always @(posedge clk) begin
        if (!rst_n) begin
            m_code = 0; m_ord = 0; m_single = 0; act = 0; bt = 0;
        end else begin
            if (start) begin
                blen  = len_of(m_code);
                if (m_single != 0 && is_write) blen = 1;
                act   = 1; bt = 0; bbase = int'(start_col); bord = m_ord;
            end else if (act != 0) begin
                if (bt == blen - 1) act = 0;
                else bt++;
            end
            if (mode_wr) begin
                m_code   = int'(mode_word[2:0]);
                m_ord    = int'(mode_word[3]);
                m_single = int'(mode_word[9]);
            end
        end
    end

    // Compare against the model on every falling edge.
    always @(negedge clk) begin
        if (rst_n) begin
            check(col_valid == (act != 0), "R3 valid", col_valid, act);
            check(burst_done == (act != 0 && bt == blen - 1), "R7 done", burst_done,
                  (act != 0 && bt == blen - 1));
            if (act != 0 && col_valid)
                check(int'(col_addr) == exp_addr(bbase, blen, bord, bt),
                      bord ? "R5 addr" : "R4 addr", col_addr, exp_addr(bbase, blen, bord, bt));
            if (cap_en && col_valid) capq.push_back(int'(col_addr));
        end
    end

    task automatic idle(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic set_mode(int w);
        @(negedge clk);
        mode_wr = 1'b1; mode_word = 13'(w);
        @(negedge clk);
        mode_wr = 1'b0;
    endtask

    task automatic fire(int col, bit wr);
        @(negedge clk);
        start = 1'b1; start_col = 12'(col); is_write = wr;
        @(negedge clk);
        start = 1'b0;
    endtask

    // Run one burst in isolation and collect its addresses.
    task automatic run_capture(int col, bit wr);
        capq.delete();
        cap_en = 1;
        fire(col, wr);
        idle(10);
        cap_en = 0;
    endtask

    task automatic check_seq(string req, int exp[$]);
        check(capq.size() == exp.size(), req, capq.size(), exp.size());
        for (int i = 0; i < exp.size() && i < capq.size(); i++)
            check(capq[i] == exp[i], req, capq[i], exp[i]);
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        checks++; failures++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        // R1: outputs quiet during reset
        repeat (3) @(negedge clk);
        check(col_valid == 1'b0, "R1 valid in reset", col_valid, 0);
        check(burst_done == 1'b0, "R1 done in reset", burst_done, 0);
        rst_n = 1'b1;
        // R1: default mode is one beat
        run_capture(12'h37B, 1'b0);
        check_seq("R1 default length", '{12'h37B});

        // R4: 4-beat sequential from offset 1
        set_mode(13'h002);
        run_capture(12'h101, 1'b0);
        check_seq("R4 seq4", '{12'h101, 12'h102, 12'h103, 12'h100});
        // R4: 8-beat sequential from offset 5, upper bits held (R6)
        set_mode(13'h003);
        run_capture(12'hA5D, 1'b0);
        check_seq("R4 R6 seq8", '{12'hA5D, 12'hA5E, 12'hA5F, 12'hA58,
                                  12'hA59, 12'hA5A, 12'hA5B, 12'hA5C});
        // R5: 8-beat interleaved from offset 5
        set_mode(13'h00B);
        run_capture(12'hA5D, 1'b0);
        check_seq("R5 int8", '{12'hA5D, 12'hA5C, 12'hA5F, 12'hA5E,
                               12'hA59, 12'hA58, 12'hA5B, 12'hA5A});
        // R6: 2-beat burst moves only bit 0
        set_mode(13'h001);
        run_capture(12'hFFF, 1'b0);
        check_seq("R6 seq2", '{12'hFFF, 12'hFFE});
        // R2: illegal length code gives one beat
        set_mode(13'h006);
        run_capture(12'h044, 1'b0);
        check_seq("R2 illegal code", '{12'h044});

        // R8: single-write mode, 4 beats
        set_mode(13'h202);
        run_capture(12'h012, 1'b1);
        check_seq("R8 write single", '{12'h012});
        run_capture(12'h012, 1'b0);
        check_seq("R8 read full", '{12'h012, 12'h013, 12'h010, 12'h011});
        // R9: normal mode write runs full length
        set_mode(13'h002);
        run_capture(12'h012, 1'b1);
        check_seq("R9 write full", '{12'h012, 12'h013, 12'h010, 12'h011});

        // R2: start together with mode_wr uses the old mode (4 beats)
        capq.delete(); cap_en = 1;
        @(negedge clk);
        mode_wr = 1'b1; mode_word = 13'h000; start = 1'b1; start_col = 12'h020; is_write = 1'b0;
        @(negedge clk);
        mode_wr = 1'b0; start = 1'b0;
        idle(8); cap_en = 0;
        check_seq("R2 same-cycle load", '{12'h020, 12'h021, 12'h022, 12'h023});

        // R10: abort an 8-beat burst after two beats
        set_mode(13'h003);
        capq.delete(); cap_en = 1;
        fire(12'h300, 1'b0);
        @(negedge clk);
        start = 1'b1; start_col = 12'h506;
        @(negedge clk);
        start = 1'b0;
        idle(10); cap_en = 0;
        check_seq("R10 abort", '{12'h300, 12'h301, 12'h506, 12'h507, 12'h500, 12'h501,
                                 12'h502, 12'h503, 12'h504, 12'h505});

        // R11: inputs changing mid-burst have no effect
        set_mode(13'h202);
        capq.delete(); cap_en = 1;
        fire(12'h0C1, 1'b0);
        start_col = 12'hFFF; is_write = 1'b1;
        idle(8); cap_en = 0;
        check_seq("R11 held inputs", '{12'h0C1, 12'h0C2, 12'h0C3, 12'h0C0});

        // Random mix, model compared every cycle (R2..R10)
        for (int i = 0; i < 300; i++) begin
            if ($urandom_range(0, 3) == 0)
                set_mode(int'($urandom_range(0, 1) << 9) | int'($urandom_range(0, 1) << 3)
                         | int'($urandom_range(0, 7)));
            fire(int'($urandom_range(0, 4095)), 1'($urandom_range(0, 1)));
            idle(int'($urandom_range(0, 9)));
        end
        idle(12);
        finish_run();
    end

endmodule